// File: doc/BRIEF.md
# Write Store Buffer with Residency Timeout

This block sits between a processor-side write port and a downstream memory port. Writes to ordinary cacheable memory are parked in a small set of line-sized slots rather than forwarded at once. A later write to a line that is already parked merges into the same slot under its byte strobes. Parked data is invisible downstream until its slot is emptied, so an outside agent that polls the location keeps reading the stale value until then.

A slot is emptied in one of four cases. It has been resident for a fixed number of cycles. A sync request forces every slot out. A write that misses a full buffer needs room. A device or strongly-ordered write has to be ordered behind older parked data. Slots always leave oldest first. The per-slot age limit is what guarantees forward progress when no further traffic arrives. A parameter removes the limit, and then parked data waits for a sync or for other traffic.

Top module: `wsb_top`

## Requirements
- R1: After reset, out_valid and sync_done are low, chk_hit is low, and in_ready is high for a normal write.
- R2: A write with in_attr = 2'b00 (normal) is accepted into a slot and not presented on the output. chk_hit is high while chk_line equals its line address (in_addr without the low log2(LINE_BYTES) bits).
- R3: With TIMEOUT_EN = 1, a slot allocated at clock edge E raises out_valid in the cycle that follows edge E+AGE_LIMIT, and not earlier unless another cause drains it. The output carries the line address with its low offset bits zero, the merged data and the OR of all strobes.
- R4: A normal write to a line that is already held merges its strobed bytes into that slot. Unstrobed bytes keep their older value. The merge does not restart the slot's age.
- R5: Slots drain in allocation order, whatever their slot index.
- R6: When every slot is occupied and a normal write misses, in_ready stays low and the oldest slot is presented on the output. The write is accepted once space is free.
- R7: A one-cycle sync_req makes every occupied slot drain. in_ready is low until completion. sync_done is a one-cycle pulse in the cycle after the last drained write was accepted downstream.
- R8: A sync_req sampled while the buffer is empty gives sync_done in the very next cycle.
- R9: A write with in_attr != 2'b00 bypasses the slots. With the buffer empty it appears on the output in the same cycle with its own address, data and strobes, and in_ready follows out_ready. With data parked, it waits until the older slots have drained.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_addr, out_data and out_strb do not change.
- R11: With TIMEOUT_EN = 0, a parked slot is never drained by age alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write request valid |
| in_ready | output | 1 | Write request accepted this cycle when high with in_valid |
| in_addr | input | ADDR_W | Byte address of the write |
| in_data | input | LINE_BYTES*8 | Line-wide write data |
| in_strb | input | LINE_BYTES | Byte enables |
| in_attr | input | 2 | Memory kind: 00 normal, 01 device, 1x strongly ordered |
| out_valid | output | 1 | Downstream write valid |
| out_ready | input | 1 | Downstream accepts the write |
| out_addr | output | ADDR_W | Downstream byte address |
| out_data | output | LINE_BYTES*8 | Downstream data |
| out_strb | output | LINE_BYTES | Downstream byte enables |
| sync_req | input | 1 | Request to flush all slots |
| sync_done | output | 1 | One-cycle flush completion pulse |
| chk_line | input | ADDR_W-log2(LINE_BYTES) | Line address to probe |
| chk_hit | output | 1 | Probed line is still held in a slot |

## Verification
The bench builds the block with two slots, 4-byte lines, a 16-bit address and an age limit of 8. A full buffer, a reordered drain and a complete timeout window therefore all arise within a few dozen cycles. At that line width all sixteen merge strobe patterns are swept, each closed by a sync. A second copy with TIMEOUT_EN = 0 receives the same first write and shows that the write stays parked long after the first copy has timed it out.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'b00,
    KIND_DEVICE = 2'b01,
    KIND_STRONG = 2'b10,
    KIND_STRONG_B = 2'b11
  } mem_kind_e;

  // Only ordinary memory may be parked in a slot.
  function automatic logic kind_parkable(input logic [1:0] kind);
    return kind == KIND_NORMAL;
  endfunction

endpackage

// File: rtl/wsb_slot.sv
module wsb_slot #(
  parameter int LINE_W     = 27,
  parameter int NBYTE      = 32,
  parameter int AGE_LIMIT  = 256,
  parameter bit TIMEOUT_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic               merge_en,
  input  logic               free_en,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic [NBYTE*8-1:0] wr_data,
  input  logic [NBYTE-1:0]   wr_strb,
  input  logic [LINE_W-1:0]  chk_line,
  output logic               occ,
  output logic [LINE_W-1:0]  line,
  output logic [NBYTE*8-1:0] data,
  output logic [NBYTE-1:0]   strb,
  output logic               hit_wr,
  output logic               hit_chk,
  output logic               aged
);

  logic               occ_q, occ_d;
  logic [LINE_W-1:0]  line_q, line_d;
  logic [NBYTE*8-1:0] data_q, data_d;
  logic [NBYTE-1:0]   strb_q, strb_d;
  logic               load_en;

  assign load_en = alloc_en | merge_en;

  always_comb begin
    occ_d  = occ_q;
    line_d = line_q;
    data_d = data_q;
    strb_d = strb_q;
    if (alloc_en) begin
      occ_d  = 1'b1;
      line_d = wr_line;
      data_d = wr_data;
      strb_d = wr_strb;
    end else if (merge_en) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (wr_strb[b]) data_d[b*8 +: 8] = wr_data[b*8 +: 8];
      end
      strb_d = strb_q | wr_strb;
    end
    if (free_en) occ_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= 1'b0;
    else        occ_q <= occ_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      line_q <= line_d;
      data_q <= data_d;
      strb_q <= strb_d;
    end
  end

  generate
    if (TIMEOUT_EN) begin : g_age
      localparam int AGE_W = $clog2(AGE_LIMIT + 1);
      localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT);
      logic [AGE_W-1:0] age_q, age_d;

      always_comb begin
        age_d = age_q;
        if (alloc_en)                          age_d = '0;
        else if (occ_q && (age_q != AGE_MAX))  age_d = age_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
      end

      assign aged = occ_q && (age_q == AGE_MAX);
    end else begin : g_no_age
      assign aged = 1'b0;
    end
  endgenerate

  assign occ     = occ_q;
  assign line    = line_q;
  assign data    = data_q;
  assign strb    = strb_q;
  assign hit_wr  = occ_q && (line_q == wr_line);
  assign hit_chk = occ_q && (line_q == chk_line);

endmodule

// File: rtl/wsb_order.sv
module wsb_order #(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] count
);

  logic [IDX_W-1:0] q_q [NSLOT];
  logic [IDX_W-1:0] q_d [NSLOT];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             q_en;

  assign q_en = push | pop;

  always_comb begin
    int tail;
    tail = int'(cnt_q);
    for (int i = 0; i < NSLOT; i++) q_d[i] = q_q[i];
    if (pop) begin
      for (int i = 0; i < NSLOT - 1; i++) q_d[i] = q_q[i+1];
      tail = tail - 1;
    end
    if (push) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (i == tail) q_d[i] = push_idx;
      end
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (q_en) q_q <= q_d;
  end

  assign head_idx = q_q[0];
  assign count    = cnt_q;

endmodule

// File: rtl/wsb_pick.sv
module wsb_pick #(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2
) (
  input  logic [NSLOT-1:0] occ,
  input  logic [NSLOT-1:0] hit,
  output logic [IDX_W-1:0] free_idx,
  output logic [IDX_W-1:0] hit_idx,
  output logic             any_hit
);

  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    any_hit  = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!occ[i]) free_idx = IDX_W'(i);
      if (hit[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wsb_top.sv
module wsb_top #(
  parameter int NSLOT      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int AGE_LIMIT  = 256,
  parameter bit TIMEOUT_EN = 1'b1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int DW        = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DW-1:0]     in_data,
  input  logic [LINE_BYTES-1:0] in_strb,
  input  logic [1:0]        in_attr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DW-1:0]     out_data,
  output logic [LINE_BYTES-1:0] out_strb,
  input  logic              sync_req,
  output logic              sync_done,
  input  logic [LINE_W-1:0] chk_line,
  output logic              chk_hit
);
  import wsb_pkg::*;

  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int CNT_W = $clog2(NSLOT + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NSLOT);

  logic [LINE_W-1:0]     in_line;
  logic [NSLOT-1:0]      occ_v, hit_v, chk_v, aged_v;
  logic [NSLOT-1:0]      alloc_v, merge_v, free_v;
  logic [LINE_W-1:0]     line_a [NSLOT];
  logic [DW-1:0]         data_a [NSLOT];
  logic [LINE_BYTES-1:0] strb_a [NSLOT];

  logic [IDX_W-1:0] free_idx, hit_idx, head_idx;
  logic             any_hit;
  logic [CNT_W-1:0] occ_cnt;

  logic buf_empty, buf_full, parkable;
  logic full_miss, bypass_wait, bypass_go, drain_req;
  logic merge_blk, accept, do_alloc, do_merge, do_pop;
  logic offer_q, offer_d;
  logic sync_busy_q, sync_busy_d;

  assign in_line  = in_addr[ADDR_W-1:OFF_W];
  assign parkable = kind_parkable(in_attr);

  // ---------------- slot storage ----------------
  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign alloc_v[s] = do_alloc && (free_idx == IDX_W'(s));
      assign merge_v[s] = do_merge && (hit_idx == IDX_W'(s));
      assign free_v[s]  = do_pop && !buf_empty && (head_idx == IDX_W'(s));

      wsb_slot #(
        .LINE_W    (LINE_W),
        .NBYTE     (LINE_BYTES),
        .AGE_LIMIT (AGE_LIMIT),
        .TIMEOUT_EN(TIMEOUT_EN)
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_en(alloc_v[s]),
        .merge_en(merge_v[s]),
        .free_en (free_v[s]),
        .wr_line (in_line),
        .wr_data (in_data),
        .wr_strb (in_strb),
        .chk_line(chk_line),
        .occ     (occ_v[s]),
        .line    (line_a[s]),
        .data    (data_a[s]),
        .strb    (strb_a[s]),
        .hit_wr  (hit_v[s]),
        .hit_chk (chk_v[s]),
        .aged    (aged_v[s])
      );
    end
  endgenerate

  wsb_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_pick (
    .occ     (occ_v),
    .hit     (hit_v),
    .free_idx(free_idx),
    .hit_idx (hit_idx),
    .any_hit (any_hit)
  );

  wsb_order #(.NSLOT(NSLOT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (do_alloc),
    .push_idx(free_idx),
    .pop     (do_pop && !buf_empty),
    .head_idx(head_idx),
    .count   (occ_cnt)
  );

  // ---------------- drain decision ----------------
  assign buf_empty   = (occ_cnt == '0);
  assign buf_full    = (occ_cnt == FULL_CNT);
  assign full_miss   = in_valid && parkable && !any_hit && buf_full && !sync_busy_q;
  assign bypass_wait = in_valid && !parkable && !buf_empty && !sync_busy_q;
  assign bypass_go   = in_valid && !parkable && buf_empty && !sync_busy_q;
  assign drain_req   = !buf_empty &&
                       (aged_v[head_idx] || sync_busy_q || full_miss || bypass_wait || offer_q);

  // A slot on offer must not change under the consumer.
  assign merge_blk = drain_req && (hit_idx == head_idx);

  always_comb begin
    if (sync_busy_q)   in_ready = 1'b0;
    else if (parkable) in_ready = any_hit ? !merge_blk : !buf_full;
    else               in_ready = buf_empty && out_ready;
  end

  assign accept   = in_valid && in_ready;
  assign do_alloc = accept && parkable && !any_hit;
  assign do_merge = accept && parkable && any_hit;
  assign do_pop   = drain_req && out_ready;

  // ---------------- output mux ----------------
  always_comb begin
    out_valid = drain_req || bypass_go;
    if (buf_empty) begin
      out_addr = in_addr;
      out_data = in_data;
      out_strb = in_strb;
    end else begin
      out_addr = {line_a[head_idx], {OFF_W{1'b0}}};
      out_data = data_a[head_idx];
      out_strb = strb_a[head_idx];
    end
  end

  // ---------------- offer hold and sync tracking ----------------
  always_comb begin
    offer_d = drain_req && !out_ready;
    if (sync_busy_q) sync_busy_d = !buf_empty;
    else             sync_busy_d = sync_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_q     <= 1'b0;
      sync_busy_q <= 1'b0;
    end else begin
      offer_q     <= offer_d;
      sync_busy_q <= sync_busy_d;
    end
  end

  assign sync_done = sync_busy_q && buf_empty;
  assign chk_hit   = |chk_v;

endmodule

// File: rtl/wsb_top_chk.sv
module wsb_top_chk #(
  parameter int NSLOT      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int AGE_LIMIT  = 256,
  parameter bit TIMEOUT_EN = 1'b1,
  parameter int CNT_W      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [1:0]            in_attr,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [ADDR_W-1:0]     out_addr,
  input logic [LINE_BYTES*8-1:0] out_data,
  input logic [LINE_BYTES-1:0] out_strb,
  input logic                  sync_req,
  input logic                  sync_done,
  input logic [CNT_W-1:0]      occ_cnt
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (sync_done) pend_q <= 1'b0;
    else if (sync_req)  pend_q <= 1'b1;
  end

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_strb)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !sync_done);

  assert_done_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> !out_valid);

  assert_sync_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !(in_valid && in_ready));

  assert_bypass_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_attr != 2'b00)) |-> (occ_cnt == '0));

  generate
    if (TIMEOUT_EN) begin : g_tmo
      localparam int RUN_W = $clog2(AGE_LIMIT + 2) + 1;
      logic [RUN_W-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           run_q <= '0;
        else if ((occ_cnt != '0) && !out_valid) run_q <= run_q + 1'b1;
        else                                  run_q <= '0;
      end

      assert_age_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(AGE_LIMIT));
    end
  endgenerate

endmodule

bind wsb_top wsb_top_chk #(
  .NSLOT     (NSLOT),
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .AGE_LIMIT (AGE_LIMIT),
  .TIMEOUT_EN(TIMEOUT_EN),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_attr  (in_attr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_data (out_data),
  .out_strb (out_strb),
  .sync_req (sync_req),
  .sync_done(sync_done),
  .occ_cnt  (occ_cnt)
);

// File: tb/wsb_top_bench.sv
module wsb_top_bench;

  localparam int NS  = 2;
  localparam int AW  = 16;
  localparam int LB  = 4;
  localparam int LIM = 8;
  localparam int LW  = AW - 2;

  logic          clk, rst_n;
  logic          in_valid, in_ready, nt_in_ready, nt_en, nt_in_valid;
  logic [AW-1:0] in_addr;
  logic [31:0]   in_data;
  logic [3:0]    in_strb;
  logic [1:0]    in_attr;
  logic          out_valid, out_ready, sync_req, sync_done, chk_hit;
  logic [AW-1:0] out_addr;
  logic [31:0]   out_data;
  logic [3:0]    out_strb;
  logic [LW-1:0] chk_line;
  logic          nt_out_valid, nt_sync_done, nt_chk_hit;
  logic [AW-1:0] nt_out_addr;
  logic [31:0]   nt_out_data;
  logic [3:0]    nt_out_strb;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign nt_in_valid = in_valid & nt_en;

  wsb_top #(.NSLOT(NS), .ADDR_W(AW), .LINE_BYTES(LB), .AGE_LIMIT(LIM), .TIMEOUT_EN(1'b1)) u_wsb_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_strb(in_strb), .in_attr(in_attr), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data), .out_strb(out_strb),
    .sync_req(sync_req), .sync_done(sync_done), .chk_line(chk_line), .chk_hit(chk_hit));

  wsb_top #(.NSLOT(NS), .ADDR_W(AW), .LINE_BYTES(LB), .AGE_LIMIT(LIM), .TIMEOUT_EN(1'b0)) u_wsb_top_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(nt_in_valid), .in_ready(nt_in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_strb(in_strb), .in_attr(in_attr), .out_valid(nt_out_valid),
    .out_ready(1'b0), .out_addr(nt_out_addr), .out_data(nt_out_data), .out_strb(nt_out_strb),
    .sync_req(1'b0), .sync_done(nt_sync_done), .chk_line(chk_line), .chk_hit(nt_chk_hit));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s, input logic [1:0] k);
    in_addr  = a;
    in_data  = d;
    in_strb  = s;
    in_attr  = k;
    in_valid = 1'b1;
    #1;
    while (!in_ready) step();
    step();
    in_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1;
    step();
    sync_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0;
    int early;
    logic [31:0] exp_d;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; in_strb = '0;
    in_attr = 2'b00; out_ready = 1'b0; sync_req = 1'b0; chk_line = '0; nt_en = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1: idle after reset
    check("R1 out_valid", out_valid, 0);
    check("R1 sync_done", sync_done, 0);
    check("R1 chk_hit", chk_hit, 0);
    check("R1 in_ready", in_ready, 1);

    // R2/R3/R4/R10/R11: park, merge, time out
    wr(16'h0100, 32'h11223344, 4'hF, 2'b00);
    t0 = cyc;
    early = 0;
    chk_line = LW'(16'h0100 >> 2);
    #1;
    check("R2 chk_hit parked line", chk_hit, 1);
    chk_line = LW'(16'h0200 >> 2);
    #1;
    check("R2 chk_hit other line", chk_hit, 0);
    chk_line = LW'(16'h0100 >> 2);
    for (int i = 0; i < 2; i++) begin
      if (out_valid) early++;
      step();
    end
    wr(16'h0102, 32'hAABBCCDD, 4'b0100, 2'b00);
    nt_en = 1'b0;
    while (cyc - t0 < LIM) begin
      if (out_valid) early++;
      step();
    end
    check("R2 held before age limit", early, 0);
    check("R3 out_valid at age limit", out_valid, 1);
    check("R3 out_addr", out_addr, 16'h0100);
    check("R4 merged data", out_data, 32'h11BB3344);
    check("R3 out_strb", out_strb, 4'hF);
    check("R11 no timeout drain", nt_out_valid, 0);
    check("R11 still held", nt_chk_hit, 1);
    early = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (!out_valid || out_addr !== 16'h0100 || out_data !== 32'h11BB3344) early++;
      if (nt_out_valid) early += 100;
    end
    check("R10 offer stable / R11 long hold", early, 0);
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    check("R3 drained", out_valid, 0);
    check("R2 chk_hit after drain", chk_hit, 0);

    // R6/R5/R7: full buffer, ordering, sync
    wr(16'h0300, 32'h00000001, 4'hF, 2'b00);
    wr(16'h0400, 32'h00000002, 4'h3, 2'b00);
    in_addr = 16'h0500; in_data = 32'h00000003; in_strb = 4'hF; in_attr = 2'b00;
    in_valid = 1'b1;
    #1;
    check("R6 in_ready low when full", in_ready, 0);
    check("R6 oldest offered", out_valid, 1);
    check("R6 oldest addr", out_addr, 16'h0300);
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    check("R6 accepted after space", in_ready, 1);
    step();
    in_valid = 1'b0;
    pulse_sync();
    check("R7 in_ready low during sync", in_ready, 0);
    check("R7 no early done", sync_done, 0);
    check("R5 first drain addr", out_addr, 16'h0400);
    check("R5 first drain strb", out_strb, 4'h3);
    out_ready = 1'b1;
    step();
    check("R5 second drain addr", out_addr, 16'h0500);
    check("R5 second drain data", out_data, 32'h00000003);
    step();
    out_ready = 1'b0;
    check("R7 sync_done", sync_done, 1);
    check("R7 drained", out_valid, 0);
    step();
    check("R7 done one cycle", sync_done, 0);

    // R8: sync on empty buffer
    pulse_sync();
    check("R8 immediate done", sync_done, 1);
    step();
    check("R8 done one cycle", sync_done, 0);

    // R9: bypass
    out_ready = 1'b1;
    in_addr = 16'h0123; in_data = 32'hCAFEF00D; in_strb = 4'h6; in_attr = 2'b01;
    in_valid = 1'b1;
    #1;
    check("R9 bypass valid", out_valid, 1);
    check("R9 bypass addr", out_addr, 16'h0123);
    check("R9 bypass data", out_data, 32'hCAFEF00D);
    check("R9 bypass strb", out_strb, 4'h6);
    check("R9 bypass ready", in_ready, 1);
    step();
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    check("R9 bypass gone", out_valid, 0);
    wr(16'h0600, 32'h00000005, 4'hF, 2'b00);
    in_addr = 16'h0700; in_data = 32'h00000007; in_strb = 4'hF; in_attr = 2'b10;
    in_valid = 1'b1;
    #1;
    check("R9 bypass waits", in_ready, 0);
    check("R9 older first", out_addr, 16'h0600);
    out_ready = 1'b1;
    step();
    check("R9 bypass after drain", out_addr, 16'h0700);
    check("R9 bypass ready after drain", in_ready, 1);
    step();
    in_valid = 1'b0;
    out_ready = 1'b0;

    // R4: sweep of merge strobes
    early = 0;
    for (int s = 0; s < 16; s++) begin
      wr(16'h0800, 32'h01020304, 4'hF, 2'b00);
      wr(16'h0801, 32'hF0E0D0C0, 4'(s), 2'b00);
      for (int b = 0; b < 4; b++)
        exp_d[b*8 +: 8] = s[b] ? 8'(32'hF0E0D0C0 >> (8*b)) : 8'(32'h01020304 >> (8*b));
      pulse_sync();
      check("R4 sweep merged data", out_data, exp_d);
      out_ready = 1'b1;
      step();
      out_ready = 1'b0;
      if (!sync_done) early++;
      step();
    end
    check("R7 sweep syncs completed", early, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule